// File: doc/BRIEF.md
# Triple Match Timer

This peripheral holds three independent 32-bit counters behind a small word-addressed register bus. Each counter has a reload value and two compare values. The counters share one packed control word, one sticky event word and one enable word for the event bits. A counter steps on a per-timer tick-enable pulse, or on a per-timer external event pulse when its control selects that source. It can count upward or downward. When it wraps it reloads from its reload register and records an overflow event. It records a compare event when a step leaves it equal to either compare register.

Software uses the block in three ways. A free-running upward counter serves as a time base. A periodic tick comes from loading the reload and count registers with all-ones minus (P-1), which gives an overflow every P steps. A one-shot deadline comes from writing a compare register with the current count plus a delta; the counter keeps running past it. A single interrupt line is high while any enabled event bit is set.

Top module: `tri_match_timer`

## Requirements
- R1: After reset the control word reads 0xA40. This runs timer 3, selects upward counting on timers 1 and 3, and leaves timer 1 stopped. Every count, reload, compare, event and enable register reads 0, and the interrupt line is low. Timer 3 then counts each tick on tick_en[2].
- R2: Word address 4*(N-1) is the count of timer N. The next three word addresses are its reload value, first compare and second compare. Word 12 is the control word, word 13 the event word, word 14 the event-enable word, and word 15 reads 0. A read strobe loads bus_rdata at the clock edge, and bus_rdata holds that value until the next read.
- R3: Timer N takes three control bits starting at bit 3*(N-1): run, source, overflow-interrupt enable. Bit 9+(N-1) selects upward counting. A timer steps only while run is 1. With source 0 it steps on tick_en[N-1], and with source 1 it steps on ext_evt[N-1].
- R4: When counting upward, a step adds one. A step taken at all-ones loads the reload value instead and sets event bit 3*(N-1)+2.
- R5: When counting downward, a step subtracts one. A step taken at zero loads the reload value and sets event bit 3*(N-1)+2.
- R6: A step that leaves the count equal to the first compare value sets event bit 3*(N-1). A step that leaves it equal to the second compare value sets event bit 3*(N-1)+1.
- R7: A write to a count register in the same cycle as a step takes the written value. No compare event is raised in that cycle.
- R8: Event bits stay set until cleared. A write to word 13 clears each bit written as 0 and leaves each bit written as 1 unchanged. An event raised in the same cycle as the clear wins, so that bit stays set.
- R9: The interrupt line is the OR over all event bits ANDed with their enable bits. An overflow bit counts only while that timer's overflow-interrupt control bit is also set.
- R10: With the reload and count registers set to all-ones minus (P-1), an upward timer raises an overflow every P steps and restarts from the reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on a read strobe |
| tick_en | input | 3 | Per-timer tick pulse (source 0) |
| ext_evt | input | 3 | Per-timer external event pulse (source 1) |
| irq | output | 1 | Combined interrupt |

## Verification
Timer 1 is driven with plain tick pulses while stopped and while running. It then gets external pulses under both source settings, which shows that the source select really switches between the two inputs. The timer is run through upward and downward wraps from a programmed reload value, and through an upward periodic run with P=3 that separates the reload path from plain wrap-to-zero. Writes and clears are made to land in the same cycle as a step or a compare hit, which exposes any wrong priority between software and hardware. Timers 2 and 3 are stepped on their own inputs to confirm that the field positions and the reset control value belong to the right timer.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
   localparam int unsigned DATA_W        = 32;
   localparam int unsigned ADDR_W        = 4;
   localparam int unsigned BITS_PER_TMR  = 3;
   localparam int unsigned DIR_BASE      = 9;
   localparam int unsigned CTRL_W        = 12;

   // word indices of the shared registers
   localparam logic [ADDR_W-1:0] IDX_CTRL = 4'd12;
   localparam logic [ADDR_W-1:0] IDX_STAT = 4'd13;
   localparam logic [ADDR_W-1:0] IDX_MASK = 4'd14;

   // control reset: timer 3 running, timers 1 and 3 counting upward
   localparam logic [CTRL_W-1:0] CTRL_RST = 12'hA40;

   // field offsets inside one timer's three-bit control group
   localparam int unsigned CF_RUN    = 0;
   localparam int unsigned CF_SRC    = 1;
   localparam int unsigned CF_OVF_IE = 2;

   // field offsets inside one timer's three-bit event group
   localparam int unsigned EF_CMP_A  = 0;
   localparam int unsigned EF_CMP_B  = 1;
   localparam int unsigned EF_WRAP   = 2;

   typedef enum logic [1:0] {
      SLOT_COUNT = 2'd0,
      SLOT_LOAD  = 2'd1,
      SLOT_CMP_A = 2'd2,
      SLOT_CMP_B = 2'd3
   } slot_e;

   typedef struct packed {
      logic run;
      logic src_ext;
      logic ovf_ie;
      logic up;
   } chan_cfg_t;
endpackage

// File: rtl/tmt_channel.sv
module tmt_channel
   import tmt_pkg::*;
#(
   parameter int unsigned CNT_W = 32
)
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  chan_cfg_t               cfg,
   input  logic                    tick,
   input  logic                    ext_evt,
   input  logic                    wr_en,
   input  slot_e                   wr_slot,
   input  logic [CNT_W-1:0]        wr_data,
   output logic [CNT_W-1:0]        cnt_q,
   output logic [CNT_W-1:0]        load_q,
   output logic [CNT_W-1:0]        cmp_a_q,
   output logic [CNT_W-1:0]        cmp_b_q,
   output logic [BITS_PER_TMR-1:0] evt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             step;
   logic             wr_cnt;
   logic             wrap;
   logic [CNT_W-1:0] cnt_d;

   assign step   = cfg.run & (cfg.src_ext ? ext_evt : tick);
   assign wr_cnt = wr_en && (wr_slot == SLOT_COUNT);

   always_comb begin
      cnt_d = cnt_q;
      wrap  = 1'b0;
      if (wr_cnt) begin
         cnt_d = wr_data;
      end else if (step) begin
         if (cfg.up) begin
            if (cnt_q == CNT_MAX) begin
               cnt_d = load_q;
               wrap  = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end else begin
            if (cnt_q == '0) begin
               cnt_d = load_q;
               wrap  = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
      end
   end

   always_comb begin
      evt            = '0;
      evt[EF_WRAP]   = wrap;
      evt[EF_CMP_A]  = step && !wr_cnt && (cnt_d == cmp_a_q);
      evt[EF_CMP_B]  = step && !wr_cnt && (cnt_d == cmp_b_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         load_q  <= '0;
         cmp_a_q <= '0;
         cmp_b_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (wr_en) begin
            case (wr_slot)
               SLOT_LOAD:  load_q  <= wr_data;
               SLOT_CMP_A: cmp_a_q <= wr_data;
               SLOT_CMP_B: cmp_b_q <= wr_data;
               default:    ;
            endcase
         end
      end
   end

   // R7: a count write always lands, whatever the step input does
   p_count_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt_q == $past(wr_data)));

   // R3: a stopped timer keeps its count unless software writes it
   p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.run && !wr_cnt) |=> $stable(cnt_q));

   // R4: upward step below all-ones adds one
   p_up_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cfg.up && !wr_cnt && (cnt_q != CNT_MAX))
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R5: downward step at zero reloads
   p_down_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cfg.up && !wr_cnt && (cnt_q == '0))
      |=> (cnt_q == $past(load_q)));
endmodule

// File: rtl/tmt_irq.sv
module tmt_irq
   import tmt_pkg::*;
#(
   parameter int unsigned NUM_TMR = 3,
   parameter bit          IRQ_REG = 1'b0
)
(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [BITS_PER_TMR*NUM_TMR-1:0] evt,
   input  logic [NUM_TMR-1:0]              ovf_ie,
   input  logic                            stat_wr,
   input  logic                            mask_wr,
   input  logic [BITS_PER_TMR*NUM_TMR-1:0] wr_bits,
   output logic [BITS_PER_TMR*NUM_TMR-1:0] stat_q,
   output logic [BITS_PER_TMR*NUM_TMR-1:0] mask_q,
   output logic                            irq
);
   localparam int unsigned STAT_W = BITS_PER_TMR * NUM_TMR;

   logic [STAT_W-1:0] gate;
   logic [STAT_W-1:0] stat_d;
   logic              irq_raw;

   for (genvar g = 0; g < NUM_TMR; g++) begin : g_gate
      assign gate[BITS_PER_TMR*g + EF_CMP_A] = 1'b1;
      assign gate[BITS_PER_TMR*g + EF_CMP_B] = 1'b1;
      assign gate[BITS_PER_TMR*g + EF_WRAP]  = ovf_ie[g];
   end

   // hardware events are ORed after the clear so they win
   assign stat_d  = (stat_wr ? (stat_q & wr_bits) : stat_q) | evt;
   assign irq_raw = |(stat_q & mask_q & gate);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= stat_d;
         if (mask_wr) mask_q <= wr_bits;
      end
   end

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;
      // R9: registered line follows an enabled event one cycle later
      p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(|(stat_q & mask_q)));
   end else begin : g_irq_comb
      assign irq = irq_raw;
      // R9: line only rises with an enabled event bit behind it
      p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (|(stat_q & mask_q)));
   end

   // R8: without a clear write no event bit drops
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> (($past(stat_q) & ~stat_q) == '0));

   // R8: a raised event is set next cycle even under a clear
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
   import tmt_pkg::*;
#(
   parameter int unsigned NUM_TMR = 3,
   parameter int unsigned CNT_W   = 32,
   parameter bit          IRQ_REG = 1'b0
)
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_TMR-1:0]  tick_en,
   input  logic [NUM_TMR-1:0]  ext_evt,
   output logic                irq
);
   localparam int unsigned STAT_W = BITS_PER_TMR * NUM_TMR;

   if (NUM_TMR < 1 || NUM_TMR > 3) begin : g_bad_num
      $error("tri_match_timer: NUM_TMR must be 1 to 3");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_width
      $error("tri_match_timer: CNT_W must be 2 to DATA_W");
   end

   logic [CTRL_W-1:0]       ctrl_q;
   logic [CNT_W-1:0]        cnt_a   [NUM_TMR];
   logic [CNT_W-1:0]        load_a  [NUM_TMR];
   logic [CNT_W-1:0]        cmp_a_a [NUM_TMR];
   logic [CNT_W-1:0]        cmp_b_a [NUM_TMR];
   logic [STAT_W-1:0]       evt_all;
   logic [NUM_TMR-1:0]      ovf_ie;
   logic [STAT_W-1:0]       stat_q;
   logic [STAT_W-1:0]       mask_q;
   logic [DATA_W-1:0]       rd_mux;
   logic                    in_tmr_space;

   assign in_tmr_space = (bus_addr < IDX_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ctrl_q <= CTRL_RST;
      else if (bus_wr && bus_addr == IDX_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
   end

   for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
      chan_cfg_t cfg;
      assign cfg.run     = ctrl_q[BITS_PER_TMR*g + CF_RUN];
      assign cfg.src_ext = ctrl_q[BITS_PER_TMR*g + CF_SRC];
      assign cfg.ovf_ie  = ctrl_q[BITS_PER_TMR*g + CF_OVF_IE];
      assign cfg.up      = ctrl_q[DIR_BASE + g];
      assign ovf_ie[g]   = cfg.ovf_ie;

      tmt_channel #(.CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg     (cfg),
         .tick    (tick_en[g]),
         .ext_evt (ext_evt[g]),
         .wr_en   (bus_wr && in_tmr_space && (bus_addr[3:2] == 2'(g))),
         .wr_slot (slot_e'(bus_addr[1:0])),
         .wr_data (bus_wdata[CNT_W-1:0]),
         .cnt_q   (cnt_a[g]),
         .load_q  (load_a[g]),
         .cmp_a_q (cmp_a_a[g]),
         .cmp_b_q (cmp_b_a[g]),
         .evt     (evt_all[BITS_PER_TMR*g +: BITS_PER_TMR])
      );
   end

   tmt_irq #(.NUM_TMR(NUM_TMR), .IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_all),
      .ovf_ie  (ovf_ie),
      .stat_wr (bus_wr && bus_addr == IDX_STAT),
      .mask_wr (bus_wr && bus_addr == IDX_MASK),
      .wr_bits (bus_wdata[STAT_W-1:0]),
      .stat_q  (stat_q),
      .mask_q  (mask_q),
      .irq     (irq)
   );

   always_comb begin
      rd_mux = '0;
      if (in_tmr_space) begin
         for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr[3:2] == 2'(i)) begin
               case (slot_e'(bus_addr[1:0]))
                  SLOT_COUNT: rd_mux = DATA_W'(cnt_a[i]);
                  SLOT_LOAD:  rd_mux = DATA_W'(load_a[i]);
                  SLOT_CMP_A: rd_mux = DATA_W'(cmp_a_a[i]);
                  default:    rd_mux = DATA_W'(cmp_b_a[i]);
               endcase
            end
         end
      end else if (bus_addr == IDX_CTRL) begin
         rd_mux = DATA_W'(ctrl_q);
      end else if (bus_addr == IDX_STAT) begin
         rd_mux = DATA_W'(stat_q);
      end else if (bus_addr == IDX_MASK) begin
         rd_mux = DATA_W'(mask_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   // R2: read data only moves on a read strobe
   p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R2: control word only moves on a write to its address
   p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == IDX_CTRL) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_tri_match_timer.sv
`timescale 1ns/1ps
module tb_tri_match_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  tick_en = '0;
   logic [2:0]  ext_evt = '0;
   logic        irq;

   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   logic        rd_seen = 1'b0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   tri_match_timer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick_en   (tick_en),
      .ext_evt   (ext_evt),
      .irq       (irq)
   );

   // monitor: compares each read result against the scoreboard queue
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         logic [31:0] e;
         string       t;
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL [scoreboard] read with nothing expected, actual %h", bus_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               n_bad++;
               $display("FAIL [%s] actual %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic drive(input logic w, input logic [3:0] a, input logic [31:0] d,
                        input logic [2:0] tk, input logic [2:0] ev);
      bus_wr = w; bus_addr = a; bus_wdata = d; tick_en = tk; ext_evt = ev;
      @(negedge clk);
      bus_wr = 1'b0; tick_en = '0; ext_evt = '0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      drive(1'b1, a, d, 3'b000, 3'b000);
   endtask

   task automatic tick(input logic [2:0] tk, input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 4'd0, 32'd0, tk, 3'b000);
   endtask

   task automatic pulse_ext(input logic [2:0] ev, input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 4'd0, 32'd0, 3'b000, ev);
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      n_cmp++;
      if (irq !== e) begin
         n_bad++;
         $display("FAIL [%s] irq actual %b expected %b", t, irq, e);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL [watchdog] run did not finish, actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(4'd12, 32'h0000_0A40, "R1 control reset");
      rd(4'd0,  32'd0, "R1 count1 reset");
      rd(4'd13, 32'd0, "R1 events reset");
      rd(4'd14, 32'd0, "R1 enables reset");
      rd(4'd8,  32'd0, "R1 count3 reset");
      chk_irq(1'b0, "R1 irq reset");

      // R2: register map readback
      wr(4'd1, 32'h0000_1234);
      wr(4'd2, 32'd5);
      wr(4'd3, 32'd7);
      rd(4'd1, 32'h0000_1234, "R2 reload1");
      rd(4'd2, 32'd5, "R2 compare A1");
      rd(4'd3, 32'd7, "R2 compare B1");
      rd(4'd15, 32'd0, "R2 unmapped word");

      // R3: stopped timer ignores ticks
      tick(3'b001, 3);
      rd(4'd0, 32'd0, "R3 stopped timer");

      // R6: compare hits while counting upward
      wr(4'd12, 32'h0000_0A41);
      tick(3'b001, 4);
      rd(4'd0, 32'd4, "R4 count after 4");
      rd(4'd13, 32'd0, "R6 no hit yet");
      tick(3'b001, 1);
      rd(4'd0, 32'd5, "R4 count after 5");
      rd(4'd13, 32'h001, "R6 compare A hit");
      tick(3'b001, 2);
      rd(4'd0, 32'd7, "R4 count after 7");
      rd(4'd13, 32'h003, "R6 compare B hit");

      // R3: source select
      pulse_ext(3'b001, 2);
      rd(4'd0, 32'd7, "R3 ext ignored on source 0");
      wr(4'd12, 32'h0000_0A43);
      pulse_ext(3'b001, 3);
      tick(3'b001, 2);
      rd(4'd0, 32'd10, "R3 ext counted on source 1");

      // R8: write-zero clear and set-wins
      wr(4'd13, 32'h0000_01FE);
      rd(4'd13, 32'h002, "R8 partial clear");
      wr(4'd2, 32'd11);
      drive(1'b1, 4'd13, 32'd0, 3'b000, 3'b001);
      rd(4'd13, 32'h001, "R8 event beats clear");
      rd(4'd0, 32'd11, "R8 count during clear");

      // R9: interrupt from enabled event
      wr(4'd14, 32'h001);
      chk_irq(1'b1, "R9 enabled compare raises irq");
      wr(4'd13, 32'd0);
      chk_irq(1'b0, "R9 cleared drops irq");
      rd(4'd13, 32'd0, "R8 full clear");

      // R7: count write wins over a step, no compare event
      drive(1'b1, 4'd0, 32'd11, 3'b000, 3'b001);
      rd(4'd0, 32'd11, "R7 write beats step");
      rd(4'd13, 32'd0, "R7 no compare on write");
      drive(1'b1, 4'd0, 32'd20, 3'b000, 3'b001);
      rd(4'd0, 32'd20, "R7 second write");

      // R4 and R10: upward wrap to reload, period 3
      wr(4'd12, 32'h0000_0A41);
      wr(4'd14, 32'h004);
      wr(4'd1, 32'hFFFF_FFFD);
      wr(4'd0, 32'hFFFF_FFFD);
      tick(3'b001, 2);
      rd(4'd0, 32'hFFFF_FFFF, "R4 reaches all-ones");
      rd(4'd13, 32'd0, "R10 no overflow before P");
      tick(3'b001, 1);
      rd(4'd0, 32'hFFFF_FFFD, "R4 wrap loads reload");
      rd(4'd13, 32'h004, "R4 overflow bit");
      chk_irq(1'b0, "R9 overflow gated by control");
      wr(4'd12, 32'h0000_0A45);
      chk_irq(1'b1, "R9 overflow passes with control bit");
      wr(4'd13, 32'd0);
      tick(3'b001, 2);
      rd(4'd13, 32'd0, "R10 quiet inside period");
      tick(3'b001, 1);
      rd(4'd13, 32'h004, "R10 overflow after P steps");
      rd(4'd0, 32'hFFFF_FFFD, "R10 restart value");

      // R5: downward counting and wrap
      wr(4'd13, 32'd0);
      wr(4'd12, 32'h0000_0845);
      wr(4'd1, 32'd4);
      wr(4'd2, 32'd3);
      wr(4'd0, 32'd1);
      tick(3'b001, 1);
      rd(4'd0, 32'd0, "R5 decrement");
      rd(4'd13, 32'd0, "R5 no event at zero");
      tick(3'b001, 1);
      rd(4'd0, 32'd4, "R5 wrap loads reload");
      rd(4'd13, 32'h004, "R5 overflow bit");
      tick(3'b001, 1);
      rd(4'd0, 32'd3, "R5 decrement after wrap");
      rd(4'd13, 32'h005, "R6 compare A while down");

      // R3 and R6: timer 2 fields
      wr(4'd13, 32'd0);
      wr(4'd14, 32'd0);
      tick(3'b010, 2);
      rd(4'd4, 32'd0, "R3 timer2 stopped");
      wr(4'd6, 32'd2);
      wr(4'd12, 32'h0000_0C4D);
      tick(3'b010, 2);
      rd(4'd4, 32'd2, "R3 timer2 counts");
      rd(4'd13, 32'h008, "R6 timer2 compare A bit");

      // R1: timer 3 runs from the reset control value
      tick(3'b100, 4);
      rd(4'd8, 32'd4, "R1 timer3 default running");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL [scoreboard] %0d reads unanswered, expected 0", exp_q.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end
endmodule